// File: doc/BRIEF.md
# Rotating Drum Word Store

This block models a decimal word memory whose words circulate past one fixed read/write head. Each word is a sign bit and ten BCD digits, which software may also treat as five two-digit character codes. The store is split into bands of fifty word slots. All bands share one free-running angular counter that stands for the drum position. The counter steps one slot every `SLOT_CYCLES` clocks and wraps from slot 49 back to slot 0.

A requester issues a single-cycle request with a four-digit BCD address, a write flag and a block flag. A drum access holds `busy` until the addressed slot is under the head. It then completes the access and reports, with `done`, how many slot advances it waited. A block read names any address of a band and returns that band's card-read area, slots 1 to 10, one word per slot time in slot order. Addresses 8000 to 8003 are register addresses, not drum locations, and are reported as such. Addresses that are out of range or not decimal are rejected.

Top module: `drum_word_store`

## Requirements
- R1: After reset `busy`, `done` and `rd_valid` are low.
- R2: A word written to a drum address is returned unchanged, sign included, by a later read of that address. Bit 40 is the sign (1 = minus) and bits 39:0 are ten BCD digits, most significant first.
- R3: The slot under the head advances once every `SLOT_CYCLES` clocks from 0 after reset and wraps 49 to 0. An access happens only when its slot is under the head. `wait_slots` equals the number of slot advances seen while busy before the first word moved, and is always below 50.
- R4: A decimal address N selects slot N mod 50 of band N div 50. Equal slots in different bands are separate words.
- R5: An address at or above `NUM_BANDS`*50, other than 8000-8003, or one with a digit above 9, raises `addr_err` with `done` one cycle after the request. It reports `wait_slots` = 0 and leaves storage untouched.
- R6: Addresses 8000, 8001, 8002 and 8003 complete one cycle after the request with `reg_hit` high and `reg_sel` = 0, 1, 2, 3. They do not touch storage.
- R7: A block read to any address of band B returns the words at slots 1 to 10 of B, in that order, as ten `rd_valid` pulses. `done` comes with the tenth pulse, and `wait_slots` counts the advances until slot 1.
- R8: On a block request the write flag is ignored and nothing is stored.
- R9: `busy` is high from the cycle after a drum request is accepted until `done`. Requests presented while busy are ignored.
- R10: A write completes with `done` and no `rd_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_block | input | 1 | 1 = block read of the band's read area |
| req_addr | input | 16 | Four BCD address digits |
| req_wdata | input | 41 | Write word: sign in bit 40, ten BCD digits |
| busy | output | 1 | Waiting for the head or streaming |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | One-cycle pulse per word read |
| rd_data | output | 41 | Word read, valid with `rd_valid` |
| wait_slots | output | 6 | Slot advances waited, valid with `done` |
| reg_hit | output | 1 | Request named a register address, valid with `done` |
| reg_sel | output | 2 | Register index 0-3, valid with `reg_hit` |
| addr_err | output | 1 | Request rejected, valid with `done` |

## Verification
The bench keeps its own model of the head position and predicts the exact wait of every access. Three situations test that model against the design: a request arriving with its slot already under the head, which must wait zero; repeated hits on one slot, which force a full-band wrap; and block reads whose start falls inside slots 1 to 10. A design with an off-by-one in the wait counter, or one that tests the slot before the counter moves, would report the wrong `wait_slots`. The bench writes the same slot in two bands, which exposes a band decode that collapses bands. It probes the top address, 1000 and a non-decimal digit, which expose an off-by-one range check or a missing digit check. Two ignored stimuli, a write strobed mid-wait and a block request carrying the write flag, are each followed by a read-back. A design that failed to ignore them would show the overwritten word.

// File: rtl/drum_pkg.sv
// Shared constants and types for the rotating drum word store.
// Assumes words are sign plus ten BCD digits and bands hold fifty slots.
package drum_pkg;
    localparam int SLOTS_PER_BAND = 50;
    localparam int SLOT_W         = 6;
    localparam int WORD_W         = 41;
    localparam int BLOCK_FIRST    = 1;
    localparam int BLOCK_LEN      = 10;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ADDR_DRUM = 2'd0,
        ADDR_REG  = 2'd1,
        ADDR_BAD  = 2'd2
    } addr_kind_e;
endpackage

// File: rtl/drum_addr_decode.sv
// Decodes a four-digit BCD address into band and slot, or classifies it
// as a register address (8000-8003) or an invalid one.
// Assumes: purely combinational; the requester holds the address while
// the strobe is high.
module drum_addr_decode
    import drum_pkg::*;
#(
    parameter int NUM_BANDS = 20
) (
    input  logic [15:0]               addr,
    output addr_kind_e                kind,
    output logic [$clog2(NUM_BANDS)-1:0] band,
    output logic [SLOT_W-1:0]         slot,
    output logic [1:0]                reg_sel
);
    localparam int BAND_W = $clog2(NUM_BANDS);
    localparam int WORDS  = NUM_BANDS * SLOTS_PER_BAND;

    logic [13:0] idx;
    logic        digits_ok;
    logic        is_reg;
    logic        in_range;

    // Convert the digits to a binary index and validate each digit.
    always_comb begin
        digits_ok = 1'b1;
        for (int k = 0; k < 4; k++) begin
            if (addr[4*k +: 4] > 4'd9) digits_ok = 1'b0;
        end
        idx = 14'(addr[15:12]) * 14'd1000 + 14'(addr[11:8]) * 14'd100
            + 14'(addr[7:4]) * 14'd10 + 14'(addr[3:0]);
    end

    // Classify the address and split it into band and slot.
    always_comb begin
        is_reg   = (addr[15:4] == 12'h800) && (addr[3:2] == 2'b00);
        in_range = idx < 14'(WORDS);
        if (is_reg)                     kind = ADDR_REG;
        else if (!digits_ok || !in_range) kind = ADDR_BAD;
        else                            kind = ADDR_DRUM;
        band    = BAND_W'(idx / 14'd50);
        slot    = SLOT_W'(idx % 14'd50);
        reg_sel = addr[1:0];
    end

    // Decoded drum locations must lie inside the configured store.
    always_comb begin
        if (kind == ADDR_DRUM) begin
            p_decode_range_r4: assert ((slot < SLOT_W'(SLOTS_PER_BAND)) && (int'(band) < NUM_BANDS));
        end
    end
endmodule

// File: rtl/drum_angle_counter.sv
// Free-running angular position of the drum: one slot every SLOT_CYCLES
// clocks, wrapping after slot 49. All bands share this position.
// Assumes SLOT_CYCLES >= 1.
module drum_angle_counter
    import drum_pkg::*;
#(
    parameter int SLOT_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] head_pos,
    output logic              head_tick
);
    localparam int PRE_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;

    generate
        if (SLOT_CYCLES > 1) begin : g_pre
            logic [PRE_W-1:0] pre;
            // Divide the clock down to the slot rate.
            always_ff @(posedge clk) begin
                if (!rst_n)                              pre <= '0;
                else if (pre == PRE_W'(SLOT_CYCLES - 1)) pre <= '0;
                else                                     pre <= pre + 1'b1;
            end
            assign head_tick = (pre == PRE_W'(SLOT_CYCLES - 1));
        end else begin : g_nopre
            assign head_tick = 1'b1;
        end
    endgenerate

    // Step the head position once per slot time, wrapping at the band end.
    always_ff @(posedge clk) begin
        if (!rst_n) head_pos <= '0;
        else if (head_tick) begin
            if (head_pos == SLOT_W'(SLOTS_PER_BAND - 1)) head_pos <= '0;
            else                                         head_pos <= head_pos + 1'b1;
        end
    end

    p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        head_pos < SLOT_W'(SLOTS_PER_BAND));
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (head_pos == SLOT_W'(SLOTS_PER_BAND - 1)) && head_tick |=> head_pos == '0);
endmodule

// File: rtl/drum_band_array.sv
// Word storage: one fifty-word array per band, written at the head slot
// and read asynchronously for the controller to register.
// Assumes band < NUM_BANDS and slot < 50 whenever we is high.
module drum_band_array
    import drum_pkg::*;
#(
    parameter int NUM_BANDS = 20
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [$clog2(NUM_BANDS)-1:0] band,
    input  logic [SLOT_W-1:0]            slot,
    input  word_t                        wdata,
    output word_t                        rdata
);
    localparam int BAND_W = $clog2(NUM_BANDS);

    word_t band_rd [NUM_BANDS];

    generate
        for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
            word_t cells [SLOTS_PER_BAND];
            // Store a word into this band when it is the one selected.
            always_ff @(posedge clk) begin
                if (we && (band == BAND_W'(b))) cells[slot] <= wdata;
            end
            assign band_rd[b] = cells[slot];
        end
    endgenerate

    assign rdata = band_rd[band];
endmodule

// File: rtl/drum_access_ctrl.sv
// Request sequencer: takes one request at a time, completes register and
// invalid addresses at once, and for drum locations waits for the target
// slot under the head, counting slot advances, then reads, writes or
// streams the band's read area.
// Assumes decode inputs follow req_addr combinationally.
module drum_access_ctrl
    import drum_pkg::*;
#(
    parameter int NUM_BANDS = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic                         req_block,
    input  word_t                        req_wdata,
    input  addr_kind_e                   dec_kind,
    input  logic [$clog2(NUM_BANDS)-1:0] dec_band,
    input  logic [SLOT_W-1:0]            dec_slot,
    input  logic [1:0]                   dec_reg_sel,
    input  logic [SLOT_W-1:0]            head_pos,
    input  logic                         head_tick,
    output logic                         mem_we,
    output logic [$clog2(NUM_BANDS)-1:0] mem_band,
    output logic [SLOT_W-1:0]            mem_slot,
    output word_t                        mem_wdata,
    input  word_t                        mem_rdata,
    output logic                         busy,
    output logic                         done,
    output logic                         rd_valid,
    output word_t                        rd_data,
    output logic [SLOT_W-1:0]            wait_slots,
    output logic                         reg_hit,
    output logic [1:0]                   reg_sel,
    output logic                         addr_err
);
    localparam int BAND_W = $clog2(NUM_BANDS);

    typedef enum logic {S_IDLE, S_WAIT} state_e;

    state_e            st;
    logic [BAND_W-1:0] band_q;
    logic [SLOT_W-1:0] tgt_slot;
    logic [3:0]        words_left;
    logic              wr_q;
    logic              started;
    logic [SLOT_W-1:0] wcnt;
    word_t             wdata_q;
    logic              at_head;

    // The pending access may proceed this cycle.
    assign at_head   = (st == S_WAIT) && (head_pos == tgt_slot);
    assign busy      = (st == S_WAIT);
    assign mem_we    = at_head && wr_q;
    assign mem_band  = band_q;
    assign mem_slot  = tgt_slot;
    assign mem_wdata = wdata_q;

    // Accept requests, wait for the head, move words and report completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            band_q     <= '0;
            tgt_slot   <= '0;
            words_left <= '0;
            wr_q       <= 1'b0;
            started    <= 1'b0;
            wcnt       <= '0;
            wdata_q    <= '0;
            done       <= 1'b0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            wait_slots <= '0;
            reg_hit    <= 1'b0;
            reg_sel    <= '0;
            addr_err   <= 1'b0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        case (dec_kind)
                            ADDR_REG: begin
                                done       <= 1'b1;
                                reg_hit    <= 1'b1;
                                reg_sel    <= dec_reg_sel;
                                addr_err   <= 1'b0;
                                wait_slots <= '0;
                            end
                            ADDR_BAD: begin
                                done       <= 1'b1;
                                reg_hit    <= 1'b0;
                                reg_sel    <= '0;
                                addr_err   <= 1'b1;
                                wait_slots <= '0;
                            end
                            default: begin
                                st         <= S_WAIT;
                                band_q     <= dec_band;
                                tgt_slot   <= req_block ? SLOT_W'(BLOCK_FIRST) : dec_slot;
                                words_left <= req_block ? 4'(BLOCK_LEN) : 4'd1;
                                wr_q       <= req_write && !req_block;
                                wdata_q    <= req_wdata;
                                started    <= 1'b0;
                                wcnt       <= '0;
                            end
                        endcase
                    end
                end
                S_WAIT: begin
                    if (at_head) begin
                        rd_valid   <= !wr_q;
                        if (!wr_q) rd_data <= mem_rdata;
                        started    <= 1'b1;
                        tgt_slot   <= tgt_slot + 1'b1;
                        words_left <= words_left - 1'b1;
                        if (words_left == 4'd1) begin
                            st         <= S_IDLE;
                            done       <= 1'b1;
                            wait_slots <= wcnt;
                            reg_hit    <= 1'b0;
                            reg_sel    <= '0;
                            addr_err   <= 1'b0;
                        end
                    end else if (head_tick && !started) begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    p_reg_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && dec_kind == ADDR_REG) |=> done && reg_hit && !addr_err && !busy && !rd_valid);
    p_bad_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && dec_kind == ADDR_BAD) |=> done && addr_err && !reg_hit && !busy && (wait_slots == '0));
    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && dec_kind == ADDR_DRUM) |=> busy && !done);
    p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_wait_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> wait_slots < SLOT_W'(SLOTS_PER_BAND));
    p_busy_band_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(band_q));
endmodule

// File: rtl/drum_word_store.sv
// Top of the rotating drum word store: address decode, shared angular
// counter, banded storage and the access sequencer.
// Assumes NUM_BANDS is 20, 40 or 80 and one request is outstanding at most.
module drum_word_store
    import drum_pkg::*;
#(
    parameter int NUM_BANDS   = 20,
    parameter int SLOT_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_block,
    input  logic [15:0] req_addr,
    input  logic [40:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic        rd_valid,
    output logic [40:0] rd_data,
    output logic [5:0]  wait_slots,
    output logic        reg_hit,
    output logic [1:0]  reg_sel,
    output logic        addr_err
);
    localparam int BAND_W = $clog2(NUM_BANDS);

    addr_kind_e        dec_kind;
    logic [BAND_W-1:0] dec_band;
    logic [SLOT_W-1:0] dec_slot;
    logic [1:0]        dec_reg_sel;
    logic [SLOT_W-1:0] head_pos;
    logic              head_tick;
    logic              mem_we;
    logic [BAND_W-1:0] mem_band;
    logic [SLOT_W-1:0] mem_slot;
    word_t             mem_wdata;
    word_t             mem_rdata;

    drum_addr_decode #(.NUM_BANDS(NUM_BANDS)) u_dec (
        .addr    (req_addr),
        .kind    (dec_kind),
        .band    (dec_band),
        .slot    (dec_slot),
        .reg_sel (dec_reg_sel)
    );

    drum_angle_counter #(.SLOT_CYCLES(SLOT_CYCLES)) u_angle (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_pos  (head_pos),
        .head_tick (head_tick)
    );

    drum_band_array #(.NUM_BANDS(NUM_BANDS)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .band  (mem_band),
        .slot  (mem_slot),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    drum_access_ctrl #(.NUM_BANDS(NUM_BANDS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_block   (req_block),
        .req_wdata   (req_wdata),
        .dec_kind    (dec_kind),
        .dec_band    (dec_band),
        .dec_slot    (dec_slot),
        .dec_reg_sel (dec_reg_sel),
        .head_pos    (head_pos),
        .head_tick   (head_tick),
        .mem_we      (mem_we),
        .mem_band    (mem_band),
        .mem_slot    (mem_slot),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .done        (done),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .wait_slots  (wait_slots),
        .reg_hit     (reg_hit),
        .reg_sel     (reg_sel),
        .addr_err    (addr_err)
    );
endmodule

// File: tb/sim_drum_word_store.sv
module sim_drum_word_store;
    localparam int NB = 20;
    localparam int SC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_block = 1'b0;
    logic [15:0] req_addr = '0;
    logic [40:0] req_wdata = '0;
    logic        busy, done, rd_valid, reg_hit, addr_err;
    logic [40:0] rd_data;
    logic [5:0]  wait_slots;
    logic [1:0]  reg_sel;

    drum_word_store #(.NUM_BANDS(NB), .SLOT_CYCLES(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_block(req_block), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
        .wait_slots(wait_slots), .reg_hit(reg_hit), .reg_sel(reg_sel), .addr_err(addr_err)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [5:0] wt;
        logic       rh;
        logic [1:0] rs;
        logic       er;
        string      tag;
    } res_t;
    typedef struct {
        logic [40:0] w;
        string       tag;
    } word_exp_t;

    res_t        res_q[$];
    word_exp_t   word_q[$];
    logic [40:0] shadow [int];
    int          n_chk = 0;
    int          n_bad = 0;
    int          bc = 0;
    bit          finished = 1'b0;

    // Bench's own count of clock edges since reset release.
    always @(posedge clk) begin
        if (!rst_n) bc <= 0;
        else        bc <= bc + 1;
    end

    task automatic check(input string tag, input bit ok, input string detail);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", tag, detail);
        end
    endtask

    function automatic logic [40:0] mkw(input bit neg, input longint v);
        logic [40:0] w;
        longint      t;
        t = v;
        w = '0;
        w[40] = neg;
        for (int k = 0; k < 10; k++) begin
            w[4*k +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return w;
    endfunction

    // Scoreboard monitor: pops expectations as results appear.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (word_q.size() == 0) begin
                    check("R10", 1'b0, $sformatf("actual rd_valid=1 expected rd_valid=0"));
                end else begin
                    word_exp_t e;
                    e = word_q.pop_front();
                    check(e.tag, rd_data == e.w,
                          $sformatf("rd_data actual %h expected %h", rd_data, e.w));
                end
            end
            if (done) begin
                if (res_q.size() == 0) begin
                    check("R9", 1'b0, "actual unexpected done expected none");
                end else begin
                    res_t r;
                    r = res_q.pop_front();
                    check(r.tag, (wait_slots == r.wt) && (reg_hit == r.rh) &&
                          (reg_sel == r.rs) && (addr_err == r.er),
                          $sformatf("wait/reg/sel/err actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                                    wait_slots, reg_hit, reg_sel, addr_err, r.wt, r.rh, r.rs, r.er));
                end
            end
        end
    end

    // Push the expected outcome of a request; called at a negedge before the accept edge.
    task automatic expect_req(input bit wr, input bit blk, input logic [15:0] a,
                              input logic [40:0] wd, input string tag);
        int   idx;
        bit   dig_ok;
        res_t r;
        dig_ok = 1'b1;
        for (int k = 0; k < 4; k++) if (a[4*k +: 4] > 4'd9) dig_ok = 1'b0;
        idx = a[15:12] * 1000 + a[11:8] * 100 + a[7:4] * 10 + a[3:0];
        r.tag = tag; r.wt = '0; r.rh = 1'b0; r.rs = '0; r.er = 1'b0;
        if (a[15:4] == 12'h800 && a[3:2] == 2'b00) begin
            r.rh = 1'b1;
            r.rs = a[1:0];
        end else if (!dig_ok || idx >= NB * 50) begin
            r.er = 1'b1;
        end else begin
            int tgt, p1;
            tgt  = blk ? 1 : idx % 50;
            p1   = ((bc + 1) / SC) % 50;
            r.wt = 6'((tgt - p1 + 50) % 50);
            if (blk) begin
                for (int k = 1; k <= 10; k++) begin
                    word_exp_t e;
                    e.w = shadow[(idx / 50) * 50 + k];
                    e.tag = tag;
                    word_q.push_back(e);
                end
            end else if (wr) begin
                shadow[idx] = wd;
            end else begin
                word_exp_t e;
                e.w = shadow[idx];
                e.tag = tag;
                word_q.push_back(e);
            end
        end
        res_q.push_back(r);
    endtask

    // Driver: issue one request and wait for its completion.
    task automatic do_req(input bit wr, input bit blk, input logic [15:0] a,
                          input logic [40:0] wd, input string tag);
        expect_req(wr, blk, a, wd, tag);
        req_valid = 1'b1; req_write = wr; req_block = blk; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R9: watchdog actual no completion expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", !busy && !done && !rd_valid,
              $sformatf("busy/done/rd_valid actual %0d%0d%0d expected 000", busy, done, rd_valid));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", !busy && !done && !rd_valid,
              $sformatf("after release actual %0d%0d%0d expected 000", busy, done, rd_valid));
        repeat (5) @(negedge clk);

        // R2 / R3: basic write then read with rotational waits.
        do_req(1, 0, 16'h0007, mkw(0, 64'd1234567890), "R2");
        do_req(0, 0, 16'h0007, '0, "R2");
        do_req(1, 0, 16'h0033, mkw(1, 64'd9876543210), "R2");
        do_req(0, 0, 16'h0033, '0, "R2");

        // R4: same slot, different band.
        do_req(1, 0, 16'h0057, mkw(1, 64'd42), "R4");
        do_req(0, 0, 16'h0007, '0, "R4");
        do_req(0, 0, 16'h0057, '0, "R4");
        do_req(1, 0, 16'h0957, mkw(0, 64'd5), "R4");
        do_req(0, 0, 16'h0957, '0, "R4");

        // R5: range boundary and invalid digits.
        do_req(1, 0, 16'h0999, mkw(0, 64'd999), "R5");
        do_req(0, 0, 16'h0999, '0, "R5");
        do_req(0, 0, 16'h1000, '0, "R5");
        do_req(0, 0, 16'h12A4, '0, "R5");
        do_req(1, 0, 16'h3999, mkw(0, 64'd7), "R5");
        do_req(1, 0, 16'h8004, mkw(0, 64'd7), "R5");
        do_req(0, 0, 16'h0999, '0, "R5");

        // R6: register addresses, including a write that must not store.
        for (int k = 0; k < 4; k++) do_req(0, 0, 16'h8000 + 16'(k), '0, "R6");
        do_req(1, 0, 16'h8002, mkw(0, 64'd1), "R6");
        do_req(0, 0, 16'h0007, '0, "R6");

        // R3: repeated hits on one slot force waits around the band.
        for (int k = 0; k < 4; k++) do_req(0, 0, 16'h0033, '0, "R3");
        repeat (7) @(negedge clk);
        do_req(0, 0, 16'h0033, '0, "R3");

        // R7: block read of band 2 read area, started from inside the band.
        for (int k = 1; k <= 10; k++) do_req(1, 0, 16'h0100 + 16'(k), mkw(k[0], 64'(k * 111)), "R7");
        do_req(1, 0, 16'h0110, mkw(0, 64'd1010), "R7");
        do_req(0, 1, 16'h0137, '0, "R7");
        do_req(0, 1, 16'h0105, '0, "R7");

        // R8: block request with the write flag streams and stores nothing.
        do_req(1, 1, 16'h0120, mkw(1, 64'd666), "R8");
        do_req(0, 0, 16'h0101, '0, "R8");
        do_req(0, 0, 16'h0120 - 16'h0010, '0, "R8");

        // R9: a request strobed while busy is ignored.
        expect_req(0, 0, 16'h0049, '0, "R9");
        req_valid = 1'b1; req_write = 1'b0; req_block = 1'b0; req_addr = 16'h0049;
        @(negedge clk);
        check("R9", busy == 1'b1, $sformatf("busy actual %0d expected 1", busy));
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0007; req_wdata = mkw(0, 64'd13);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        do_req(0, 0, 16'h0007, '0, "R9");

        repeat (4) @(negedge clk);
        check("R7", (word_q.size() == 0) && (res_q.size() == 0),
              $sformatf("pending actual %0d/%0d expected 0/0", word_q.size(), res_q.size()));
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule